// File: doc/BRIEF.md
# Protected Region Erase Controller

This controller guards a partitioned non-volatile memory made of one data region, one boot region and two or more main code regions. It owns one protection bit per region, drives a one-cycle erase strobe to each region and waits for that region's erase-done reply. Software may add protection at any time. Protection is removed only by a full wipe that erases every region, data region first. A protected region can never be unlocked on its own.

A programming interface issues three commands: erase one region, wipe everything, or set protection bits. The controller also produces a per-region write-permit output and a debug-enable output. Debug is open only when no region is protected.

The protection bits and a wipe-pending flag live in a persistent domain that has its own initialisation input. The functional reset leaves them alone. If a wipe is cut short by a reset, the whole sequence starts again from the data region once reset is released.

Top module: `nvp_ctrl`

## Requirements
- R1: After persistent-state initialisation and reset, every protection bit is 0, `dbg_en` is 1, `busy` is 0, `wr_allow` is all ones and no erase strobe is active.
- R2: Command code 3 (protect) ORs `cmd_mask` into the protection bits, where bit i stands for region i (region 0 = data, 1 = boot, 2 and up = main code). No protect command ever clears a bit, and a zero mask changes nothing.
- R3: Command code 1 (erase one) gives exactly one strobe, to region `cmd_region`. All protection bits stay as they were, whether or not the target region is protected.
- R4: Command code 2 (wipe) strobes every region once, in ascending index order starting with the data region. The controller strobes the next region only after the previous region has reported erase-done.
- R5: The protection bits clear together only in the cycle after the last region reports erase-done during a wipe. `dbg_en` is 1 exactly when all protection bits are 0.
- R6: `wr_allow[i]` is 1 only when region i is unprotected, the controller is idle and no wipe is pending.
- R7: A command presented while `busy` is 1 is ignored. It causes no strobe and no change to the protection bits.
- R8: If `rst_n` is asserted during a wipe, the protection bits and the pending flag are kept. After release, the wipe restarts from region 0 and runs through every region.
- R9: An erase strobe lasts one cycle, and at most one region is strobed in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous functional reset (sequencer only) |
| nv_init_n | input | 1 | Active-low initialisation of the persistent protection state |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 1 erase one, 2 wipe all, 3 protect, 0 no operation |
| cmd_region | input | $clog2(NUM_MAIN+2) | Target region for erase-one |
| cmd_mask | input | NUM_MAIN+2 | Protection bits to set for protect |
| erase_done | input | NUM_MAIN+2 | Per-region erase completion reply |
| erase_stb | output | NUM_MAIN+2 | Per-region one-cycle erase strobe |
| prot | output | NUM_MAIN+2 | Current protection bits |
| wipe_pending | output | 1 | Persistent flag: a wipe has started and has not finished |
| busy | output | 1 | Controller is erasing or has a wipe pending |
| dbg_en | output | 1 | Debug access permitted |
| wr_allow | output | NUM_MAIN+2 | Per-region permission to load new contents |

## Verification
The assertions assume that a region raises `erase_done` only after it has been strobed, and that `erase_done` is a single-cycle reply. They also assume that both reset inputs are low at time zero. The bench meets these conditions with a behavioural region model. The model answers each strobe after a fixed latency that differs per region. It keeps its replies running through a functional reset, so a stale reply from the interrupted region can arrive while the restarted wipe waits on region 0. The bench changes command inputs only at falling edges.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_ERASE_ONE = 2'd1,
    OP_WIPE_ALL  = 2'd2,
    OP_PROTECT   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STROBE = 2'd1,
    SQ_WAIT   = 2'd2
  } seq_e;
endpackage

// File: rtl/nvp_seq.sv
module nvp_seq #(
  parameter int NR = 4,
  localparam int RW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe_pending,
  input  logic          go_one,
  input  logic [RW-1:0] one_region,
  input  logic [NR-1:0] erase_done,
  output logic [NR-1:0] erase_stb,
  output logic          seq_idle,
  output logic          wipe_finish
);
  import nvp_pkg::*;

  localparam logic [RW-1:0] LAST = RW'(NR - 1);

  seq_e          st;
  logic [RW-1:0] idx;
  logic          all_mode;
  logic          cur_done;

  assign cur_done    = erase_done[idx];
  assign seq_idle    = (st == SQ_IDLE);
  assign wipe_finish = (st == SQ_WAIT) && all_mode && cur_done && (idx == LAST);

  for (genvar r = 0; r < NR; r++) begin : g_stb
    assign erase_stb[r] = (st == SQ_STROBE) && (idx == RW'(r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      idx      <= '0;
      all_mode <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (wipe_pending) begin
            st       <= SQ_STROBE;
            idx      <= '0;
            all_mode <= 1'b1;
          end else if (go_one) begin
            st       <= SQ_STROBE;
            idx      <= one_region;
            all_mode <= 1'b0;
          end
        end
        SQ_STROBE: st <= SQ_WAIT;
        SQ_WAIT: begin
          if (cur_done) begin
            if (all_mode && (idx != LAST)) begin
              idx <= idx + 1'b1;
              st  <= SQ_STROBE;
            end else begin
              st <= SQ_IDLE;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvp_nv.sv
module nvp_nv #(
  parameter int NR = 4
) (
  input  logic          clk,
  input  logic          nv_init_n,
  input  logic          ev_protect,
  input  logic [NR-1:0] set_mask,
  input  logic          ev_wipe_req,
  input  logic          ev_wipe_finish,
  output logic [NR-1:0] prot,
  output logic          wipe_pending
);
  function automatic logic [NR-1:0] f_raise(input logic [NR-1:0] cur, input logic [NR-1:0] add);
    return cur | add;
  endfunction

  always_ff @(posedge clk or negedge nv_init_n) begin
    if (!nv_init_n) begin
      prot         <= '0;
      wipe_pending <= 1'b0;
    end else if (ev_wipe_finish) begin
      prot         <= '0;
      wipe_pending <= 1'b0;
    end else begin
      if (ev_protect)  prot         <= f_raise(prot, set_mask);
      if (ev_wipe_req) wipe_pending <= 1'b1;
    end
  end
endmodule

// File: rtl/nvp_ctrl.sv
module nvp_ctrl #(
  parameter int NUM_MAIN = 2,
  localparam int NR = NUM_MAIN + 2,
  localparam int RW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_init_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_region,
  input  logic [NR-1:0] cmd_mask,
  input  logic [NR-1:0] erase_done,
  output logic [NR-1:0] erase_stb,
  output logic [NR-1:0] prot,
  output logic          wipe_pending,
  output logic          busy,
  output logic          dbg_en,
  output logic [NR-1:0] wr_allow
);
  import nvp_pkg::*;

  localparam logic [RW:0] NR_L = (RW + 1)'(NR);

  function automatic logic f_dbg_open(input logic [NR-1:0] p);
    return ~|p;
  endfunction

  function automatic logic [NR-1:0] f_writable(input logic [NR-1:0] p, input logic b);
    return b ? '0 : ~p;
  endfunction

  logic seq_idle;
  logic accept;
  logic ev_erase_one;
  logic ev_wipe_req;
  logic ev_protect;
  logic ev_wipe_finish;

  assign accept       = rst_n && cmd_valid && seq_idle && !wipe_pending;
  assign ev_erase_one = accept && (op_e'(cmd_op) == OP_ERASE_ONE) && ({1'b0, cmd_region} < NR_L);
  assign ev_wipe_req  = accept && (op_e'(cmd_op) == OP_WIPE_ALL);
  assign ev_protect   = accept && (op_e'(cmd_op) == OP_PROTECT);

  nvp_seq #(.NR(NR)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .wipe_pending (wipe_pending),
    .go_one       (ev_erase_one),
    .one_region   (cmd_region),
    .erase_done   (erase_done),
    .erase_stb    (erase_stb),
    .seq_idle     (seq_idle),
    .wipe_finish  (ev_wipe_finish)
  );

  nvp_nv #(.NR(NR)) u_nv (
    .clk            (clk),
    .nv_init_n      (nv_init_n),
    .ev_protect     (ev_protect),
    .set_mask       (cmd_mask),
    .ev_wipe_req    (ev_wipe_req),
    .ev_wipe_finish (ev_wipe_finish),
    .prot           (prot),
    .wipe_pending   (wipe_pending)
  );

  assign busy     = !seq_idle || wipe_pending;
  assign dbg_en   = f_dbg_open(prot);
  assign wr_allow = f_writable(prot, busy);
endmodule

// File: rtl/nvp_check.sv
module nvp_check #(
  parameter int NR = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nv_init_n,
  input logic [NR-1:0] erase_stb,
  input logic [NR-1:0] prot,
  input logic          wipe_pending,
  input logic          dbg_en,
  input logic          ev_wipe_finish
);
  logic [NR-1:0] seen;

  always_ff @(posedge clk or negedge rst_n or negedge nv_init_n) begin
    if (!rst_n || !nv_init_n) seen <= '0;
    else if (!wipe_pending)   seen <= '0;
    else                      seen <= seen | erase_stb;
  end

  assert_stb_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    $onehot0(erase_stb));

  assert_stb_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    (|erase_stb) |=> (erase_stb == '0));

  assert_one_erase_keeps_prot_R3: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    ((|erase_stb) && !wipe_pending) |=> $stable(prot));

  assert_wipe_starts_data_R4: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    (wipe_pending && (|erase_stb) && (seen == '0)) |-> erase_stb[0]);

  assert_finish_after_all_R5: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    ev_wipe_finish |-> (&seen));

  assert_prot_falls_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    (|($past(prot) & ~prot)) |-> $past(ev_wipe_finish));

  assert_dbg_opens_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
    $rose(dbg_en) |-> $past(ev_wipe_finish));
endmodule

bind nvp_ctrl nvp_check #(.NR(NR)) u_nvp_check (
  .clk            (clk),
  .rst_n          (rst_n),
  .nv_init_n      (nv_init_n),
  .erase_stb      (erase_stb),
  .prot           (prot),
  .wipe_pending   (wipe_pending),
  .dbg_en         (dbg_en),
  .ev_wipe_finish (ev_wipe_finish)
);

// File: tb/test_nvp_ctrl.sv
module test_nvp_ctrl;
  localparam int NR = 4;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          nv_init_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [RW-1:0] cmd_region = '0;
  logic [NR-1:0] cmd_mask = '0;
  logic [NR-1:0] erase_done;
  logic [NR-1:0] erase_stb;
  logic [NR-1:0] prot;
  logic          wipe_pending;
  logic          busy;
  logic          dbg_en;
  logic [NR-1:0] wr_allow;

  int compared = 0;
  int mismatched = 0;
  int slog[$];
  int cnt [NR];

  always #2 clk = ~clk;

  nvp_ctrl #(.NUM_MAIN(2)) i_nvp_ctrl (
    .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_region(cmd_region), .cmd_mask(cmd_mask),
    .erase_done(erase_done), .erase_stb(erase_stb), .prot(prot),
    .wipe_pending(wipe_pending), .busy(busy), .dbg_en(dbg_en), .wr_allow(wr_allow)
  );

  // Region model: reply 2+r cycles after a strobe, one-cycle pulse
  for (genvar r = 0; r < NR; r++) begin : g_mem
    initial cnt[r] = 0;
    always @(posedge clk) begin
      if (erase_stb[r]) cnt[r] <= 2 + r;
      else if (cnt[r] > 0) cnt[r] <= cnt[r] - 1;
    end
    assign erase_done[r] = (cnt[r] == 1);
  end

  always @(negedge clk) begin
    if (rst_n && nv_init_n) begin
      for (int r = 0; r < NR; r++) if (erase_stb[r]) slog.push_back(r);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input int op, input int region, input int mask);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = op[1:0];
    cmd_region = region[RW-1:0];
    cmd_mask   = mask[NR-1:0];
    @(negedge clk);
    cmd_valid  = 1'b0;
    cmd_op     = 2'd0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " idle reached"}, int'(busy), 0);
  endtask

  task automatic chk_order(input string req);
    chk({req, " strobe count"}, slog.size(), NR);
    for (int i = 0; i < NR && i < slog.size(); i++)
      chk({req, " strobe order"}, slog[i], i);
  endtask

  task automatic wipe_and_check(input string tag);
    slog.delete();
    send(2, 0, 0);
    chk("R6 no write while wipe pending", int'(wr_allow), 0);
    wait_idle("R4");
    chk_order({"R4 ", tag});
    chk("R5 protection cleared after wipe", int'(prot), 0);
    chk("R5 debug open after wipe", int'(dbg_en), 1);
    chk("R6 all writable after wipe", int'(wr_allow), 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nv_init_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 prot reset", int'(prot), 0);
    chk("R1 dbg_en reset", int'(dbg_en), 1);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 wr_allow reset", int'(wr_allow), 15);
    chk("R1 strobe idle", int'(erase_stb), 0);

    // Unprotected single-region erases
    for (int r = 0; r < NR; r++) begin
      slog.delete();
      send(1, r, 0);
      chk("R6 no write during erase", int'(wr_allow), 0);
      wait_idle("R3");
      chk("R3 single strobe count", slog.size(), 1);
      if (slog.size() > 0) chk("R3 strobed region", slog[0], r);
      chk("R3 prot untouched", int'(prot), 0);
      chk("R6 writable after erase", int'(wr_allow), 15);
    end

    // Sweep every nonzero protection mask
    for (int m = 1; m < 16; m++) begin
      send(3, 0, m);
      chk("R2 protect sets mask", int'(prot), m);
      chk("R5 debug closed", int'(dbg_en), 0);
      chk("R6 writable only unprotected", int'(wr_allow), (~m) & 15);
      send(3, 0, 0);
      chk("R2 zero mask keeps bits", int'(prot), m);
      send(3, 0, 1 << (m % NR));
      chk("R2 protect accumulates", int'(prot), m | (1 << (m % NR)));
      for (int r = 0; r < NR; r++) begin
        slog.delete();
        send(1, r, 0);
        wait_idle("R3");
        chk("R3 protected-set erase count", slog.size(), 1);
        if (slog.size() > 0) chk("R3 protected-set erase region", slog[0], r);
        chk("R3 erase leaves prot", int'(prot), m | (1 << (m % NR)));
      end
      wipe_and_check($sformatf("mask %0d", m));
    end

    // Commands during a wipe are ignored
    send(3, 0, 5);
    slog.delete();
    send(2, 0, 0);
    send(3, 0, 15);
    send(1, 2, 0);
    chk("R7 protect ignored while busy", int'(prot), 5);
    wait_idle("R7");
    chk_order("R7 no extra strobes");
    chk("R7 prot after ignored cmds", int'(prot), 0);

    // Reset in the middle of a wipe
    send(3, 0, 10);
    slog.delete();
    send(2, 0, 0);
    begin
      int n = 0;
      while (slog.size() < 2 && n < 1000) begin
        @(negedge clk);
        n++;
      end
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 prot held in reset", int'(prot), 10);
    chk("R8 pending held in reset", int'(wipe_pending), 1);
    chk("R8 debug closed in reset", int'(dbg_en), 0);
    chk("R9 no strobe in reset", int'(erase_stb), 0);
    repeat (3) @(negedge clk);
    slog.delete();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 prot held after release", int'(prot), 10);
    wait_idle("R8");
    chk_order("R8 restart");
    chk("R8 prot cleared after restart", int'(prot), 0);
    chk("R8 debug open after restart", int'(dbg_en), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule